// File: doc/BRIEF.md
# Two-Phase Hardware Barrier

This block is a synchronization point shared by a group of processors. Each processor signals with a one-cycle arrive pulse that it has reached the barrier and then waits for its own release line. Nobody is let through until the whole group has checked in. Once it has, every processor gets a one-cycle release at the same time.

The block runs in two alternating phases around a single shared counter. In the gather phase each new arrival adds to the counter, and several processors may arrive in the same cycle. When the counter reaches the group size, the block enters the leave phase. There the released processors are counted back down to zero before gathering opens again.

An arrive pulse that cannot be taken is not lost. This covers a pulse that lands during the leave phase and a second pulse from a processor that has already checked in. The pulse is held for its processor and taken by the next episode. This stops a fast processor from completing the current episode early or slipping into it twice.

Top module: `barrier_sync`

## Requirements
- R1: After reset, release_o is all zeros and the gather phase is open, so the first arrive pulses are accepted.
- R2: No release_o bit rises while any processor has not delivered an arrive pulse that has not yet been used by an earlier episode.
- R3: When the edge that samples an arrive pulse brings the number of checked-in processors to N_PROC, release_o is all ones in the next cycle.
- R4: release_o is a one-cycle pulse: after a cycle with any release_o bit high, the next cycle has release_o all zeros.
- R5: Arrive pulses from several processors in the same cycle are all accepted at that edge. If the barrier is empty and all processors pulse together, release_o is all ones in the next cycle.
- R6: An arrive pulse that comes in the cycle when release_o is high is held for its processor and counts toward the following episode.
- R7: A second arrive pulse from a processor that has already checked in to the current episode does not count again in that episode. It is held and counts toward the next episode.
- R8: After a release, a new episode again needs an arrival from every processor (held ones included) before the next release.
- R9: release_o is always either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_PROC | One-cycle arrive pulse, one bit per processor |
| release_o | output | N_PROC | One-cycle release pulse, one bit per processor |

## Verification
The checker keeps its own arrival credit for each processor. On every cycle it checks three things: that a release never goes to a processor without an unspent credit, that a release is a single all-or-none pulse, and that a simultaneous full arrival into an empty barrier releases on the next cycle. Some behaviours can only be shown by the bench's scenarios, driven against a reference model. These are the exact release cycle after a staggered gather, an arrival held across the leave cycle, a duplicate arrival deferred to the next episode, and a new episode that needs a fresh full set.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  typedef enum logic {
    PH_GATHER = 1'b0,
    PH_LEAVE  = 1'b1
  } phase_e;
endpackage

// File: rtl/barrier_popcnt.sv
module barrier_popcnt #(
  parameter int unsigned W  = 4,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int unsigned k = 0; k < W; k++) cnt_o = cnt_o + CW'(bits_i[k]);
  end
endmodule

// File: rtl/barrier_intake.sv
module barrier_intake
  import barrier_pkg::*;
#(
  parameter int unsigned N_PROC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [N_PROC-1:0] arrive_i,
  output logic [N_PROC-1:0] take_o,
  output logic [N_PROC-1:0] arrived_o
);
  for (genvar g = 0; g < N_PROC; g++) begin : g_lane
    logic arrived_q, held_q;
    logic arrived_d, held_d, take;

    always_comb begin
      take      = 1'b0;
      arrived_d = arrived_q;
      held_d    = held_q;
      if (phase_i == PH_GATHER) begin
        // a held or fresh pulse is used once per episode
        take      = (arrive_i[g] | held_q) & ~arrived_q;
        arrived_d = arrived_q | take;
        held_d    = arrived_q & (held_q | arrive_i[g]);
      end else begin
        arrived_d = 1'b0;
        held_d    = held_q | arrive_i[g];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arrived_q <= 1'b0;
        held_q    <= 1'b0;
      end else begin
        arrived_q <= arrived_d;
        held_q    <= held_d;
      end
    end

    assign take_o[g]    = take;
    assign arrived_o[g] = arrived_q;
  end
endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned CW     = $clog2(N_PROC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] take_cnt_i,
  input  logic [CW-1:0] leave_cnt_i,
  output phase_e        phase_o
);
  localparam logic [CW-1:0] FULL = CW'(N_PROC);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_GATHER) begin
      cnt_d = cnt_q + take_cnt_i;
      if (cnt_d == FULL) phase_d = PH_LEAVE;
    end else begin
      cnt_d = cnt_q - leave_cnt_i;
      if (cnt_d == '0) phase_d = PH_GATHER;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_GATHER;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
  import barrier_pkg::*;
#(
  parameter int unsigned N_PROC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PROC-1:0] arrive_i,
  output logic [N_PROC-1:0] release_o
);
  localparam int unsigned CW = $clog2(N_PROC + 1);

  phase_e            phase;
  logic [N_PROC-1:0] take, arrived;
  logic [CW-1:0]     take_cnt, leave_cnt;

  barrier_intake #(.N_PROC(N_PROC)) u_intake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .arrive_i  (arrive_i),
    .take_o    (take),
    .arrived_o (arrived)
  );

  barrier_popcnt #(.W(N_PROC), .CW(CW)) u_take_cnt (
    .bits_i (take),
    .cnt_o  (take_cnt)
  );

  barrier_popcnt #(.W(N_PROC), .CW(CW)) u_leave_cnt (
    .bits_i (release_o),
    .cnt_o  (leave_cnt)
  );

  barrier_ctrl #(.N_PROC(N_PROC), .CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_cnt_i  (take_cnt),
    .leave_cnt_i (leave_cnt),
    .phase_o     (phase)
  );

  assign release_o = (phase == PH_LEAVE) ? arrived : '0;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int unsigned N_PROC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PROC-1:0] arrive_i,
  input logic [N_PROC-1:0] release_o
);
  logic [N_PROC-1:0] has_cred, no_cred;

  for (genvar g = 0; g < N_PROC; g++) begin : g_cred
    logic [1:0] cred_q;
    logic [2:0] nxt;
    always_comb begin
      nxt = {1'b0, cred_q} + {2'b0, arrive_i[g]};
      if (release_o[g] && nxt != 3'd0) nxt = nxt - 3'd1;
      if (nxt > 3'd3) nxt = 3'd3;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cred_q <= 2'd0;
      else         cred_q <= nxt[1:0];
    end
    assign has_cred[g] = (cred_q != 2'd0);
    assign no_cred[g]  = (cred_q == 2'd0);
  end

  AST_REL_NEEDS_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o != '0) |-> (&has_cred));  // R2

  AST_REL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o != '0) |=> (release_o == '0));  // R4

  AST_REL_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o == '0) || (release_o == '1));  // R9

  AST_FULL_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&arrive_i) && (&no_cred) && (release_o == '0)) |=> (release_o == '1));  // R5
endmodule

bind barrier_sync barrier_sync_chk #(.N_PROC(N_PROC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arrive_i  (arrive_i),
  .release_o (release_o)
);

// File: tb/sim_barrier_sync.sv
`timescale 1ns/1ps
module sim_barrier_sync;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] arrive_i = '0;
  logic [N-1:0] release_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  // reference state
  bit           m_leave = 1'b0;
  logic [N-1:0] m_in = '0, m_held = '0;

  barrier_sync #(.N_PROC(N)) u0 (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int ones(logic [N-1:0] v);
    int c = 0;
    for (int k = 0; k < N; k++) c += v[k];
    return c;
  endfunction

  task automatic model_edge(logic [N-1:0] a);
    logic [N-1:0] use_now;
    if (m_leave) begin
      m_held  = m_held | a;
      m_in    = '0;
      m_leave = 1'b0;
    end else begin
      use_now = (a | m_held) & ~m_in;
      m_held  = m_in & (m_held | a);
      m_in    = m_in | use_now;
      if (ones(m_in) == N) m_leave = 1'b1;
    end
  endtask

  task automatic check(string tag, logic [N-1:0] exp);
    checks++;
    if (release_o !== exp) begin
      failures++;
      $display("FAIL %s: release actual=%b expected=%b", tag, release_o, exp);
    end
  endtask

  task automatic cyc(logic [N-1:0] a, string tag);
    arrive_i = a;
    @(posedge clk_i);
    model_edge(a);
    @(negedge clk_i);
    arrive_i = '0;
    check(tag, m_leave ? m_in : '0);
    checks++;
    if (release_o !== '0 && release_o !== ALL) begin
      failures++;
      $display("FAIL R9: release actual=%b expected=all-or-none", release_o);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0421));
    repeat (3) @(negedge clk_i);
    check("R1", '0);
    rst_ni = 1'b1;

    cyc('0, "R1");
    // full burst from empty
    cyc(ALL, "R5");
    cyc('0, "R4");
    // staggered gather
    cyc(4'b0001, "R2"); cyc(4'b0010, "R2"); cyc(4'b0100, "R2");
    cyc(4'b1000, "R3");
    cyc('0, "R4");
    // duplicate arrival deferred
    cyc(4'b0001, "R7"); cyc(4'b0001, "R7");
    cyc(4'b0010, "R7"); cyc(4'b0100, "R7");
    cyc(4'b1000, "R3");
    cyc('0, "R7");
    cyc(4'b1110, "R7");
    // arrival during the leave cycle is held
    cyc(4'b0100, "R6");
    cyc(4'b1011, "R6");
    cyc('0, "R4");
    // new episode needs the full set again
    cyc(4'b0111, "R8"); cyc('0, "R8"); cyc('0, "R8");
    cyc(4'b1000, "R3");
    cyc('0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] a;
      for (int k = 0; k < N; k++) a[k] = ($urandom % 4) == 0;
      cyc(a, (i % 2) ? "R3" : "R2");
    end
    for (int i = 0; i < 4; i++) cyc('0, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule